// File: doc/BRIEF.md
# Six-Channel Memory-to-Memory DMA Controller

The controller holds six independent copy channels behind a 32-bit register port. Software programs a channel's source address, destination address, unit count and command word, then sets the channel's run bits. Once the global control word is also enabled and not halted, a single transfer engine moves data for that channel through a memory port. Each access is one request on a valid/ready handshake, and only one access is outstanding at a time. Every word is read from the source and then written to the destination before the next read starts.

Work is measured in units. A unit is 1, 2, 4, 16 or 32 bytes. The two short units are one narrow access. The wider units are a run of consecutive 32-bit words. When several channels are eligible, the engine serves them round-robin, one whole unit per grant. When a channel's count reaches zero, the channel marks itself done. It also raises its interrupt-pending bit if its command allows that. An illegal unit code faults the channel without any memory traffic.

The engine has three states:
- ST_IDLE looks at the round-robin grant. It goes to ST_READ for a legal unit with a nonzero count. Otherwise it stays in ST_IDLE and posts a zero-count or fault event.
- ST_READ waits for the read handshake, then goes to ST_WRITE.
- ST_WRITE waits for the write handshake. It then goes back to ST_READ for the next word of the unit, or to ST_IDLE after the last word, posting a unit-complete event.

Top module: `mdma_ctrl`

## Requirements
- R1: After reset, every channel register and the global control word read as zero, the pending word reads zero, `irq` is low and `mem_valid` is low.
- R2: Channel n occupies bytes n*0x20 to n*0x20+0x1F. Its word offsets are 0x00 source, 0x04 destination, 0x08 count, 0x0C request type, 0x10 status, 0x14 command and 0x18 descriptor.
- R2 (continued): The global control word is at 0x300 and the pending word at 0x304. Writable bits read back through these masks: status 0x8000005F, command 0x00C0F783, control 0x0000030D. Any other address reads zero.
- R3: A channel moves data only while five conditions hold:
  - status bit 0 (enable) is set;
  - status bit 31 (direct mode) is set;
  - status bit 2 (halt) is clear;
  - status bit 3 (done) is clear;
  - control bit 0 is set and control bit 3 (global halt) is clear.
- R4: Command bits 10:8 select the unit. Code 0 is 4 bytes (one word), 1 is 1 byte, 2 is 2 bytes, 3 is 16 bytes (four words) and 4 is 32 bytes (eight words). `mem_size` is 0 for byte accesses, 1 for halfword accesses and 2 for word accesses, and never 3.
- R5: Each word is one read (`mem_we`=0) at the source address, followed by one write (`mem_we`=1) of the same data at the destination address. While `mem_valid` is high and `mem_ready` is low, address, direction and write data hold steady.
- R6: Command bits 23 and 22 select incrementing source and destination addresses. With incrementing on, word i of a unit is at base+4i and the base advances by the unit's byte size after the unit. With incrementing off, every access uses the base unchanged.
- R7: The count register drops by one after each completed unit and always reads the number of units still to move.
- R8: When the count reaches zero, status bits 3 (done) and 1 (count terminated) are set. A channel started with count zero sets both without any memory access.
- R9: Pending bit n equals channel n's done bit ANDed with its command bit 1. `irq` is high when any pending bit is high. Writing the status word to clear done drops the pending bit.
- R10: A unit code from 5 to 7 sets status bits 4 (address error) and 2 (halt) and global control bit 2, and performs no memory access.
- R11: Eligible channels are granted round-robin starting after the last channel served, one unit per grant, so two busy channels alternate units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request; read data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| irq | output | 1 | OR of all pending bits |

## Verification
Several properties are checked on every cycle:
- a stalled memory request keeps its address, direction and data;
- a completed read is always followed at once by a write;
- no access size outside the three legal ones appears;
- nothing starts while the global word is off or halted;
- a fault always leaves the global error bit set;
- `irq` only rises after an engine event or a register write.

The data itself, the address stepping for each unit size, the count and done behaviour, the gating by each single run bit, and the alternation between two busy channels can only be shown by the bench's scenarios. Those scenarios compare the memory image and the logged write addresses against values computed in the bench.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_UNIT,
        EV_ZERO,
        EV_FAULT
    } ev_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } eng_state_e;

    localparam int SB_EN     = 0;
    localparam int SB_TERM   = 1;
    localparam int SB_HALT   = 2;
    localparam int SB_DONE   = 3;
    localparam int SB_AERR   = 4;
    localparam int SB_DIRECT = 31;

    localparam int CB_SINC = 23;
    localparam int CB_DINC = 22;
    localparam int CB_IE   = 1;

    localparam int GB_EN   = 0;
    localparam int GB_AERR = 2;
    localparam int GB_HALT = 3;

    localparam logic [31:0] STAT_MASK = 32'h8000_005F;
    localparam logic [31:0] CMD_MASK  = 32'h00C0_F783;
    localparam logic [31:0] GCTL_MASK = 32'h0000_030D;

    function automatic logic code_ok(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic [5:0] unit_bytes(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd4;
            3'd1:    return 6'd1;
            3'd2:    return 6'd2;
            3'd3:    return 6'd16;
            3'd4:    return 6'd32;
            default: return 6'd0;
        endcase
    endfunction

    function automatic logic [3:0] unit_words(input logic [2:0] code);
        case (code)
            3'd3:    return 4'd4;
            3'd4:    return 4'd8;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [1:0] unit_msize(input logic [2:0] code);
        case (code)
            3'd1:    return 2'd0;
            3'd2:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/mdma_chan.sv
module mdma_chan
    import mdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_off,
    input  logic [31:0]   wr_data,
    input  logic          ev_hit,
    input  ev_kind_e      ev_kind,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [31:0]   cnt,
    output logic [31:0]   rtype,
    output logic [31:0]   stat,
    output logic [31:0]   cmd,
    output logic [31:0]   desc,
    output logic          runnable
);

    logic [AW-1:0] step;
    assign step = AW'(unit_bytes(cmd[10:8]));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src   <= '0;
            dst   <= '0;
            cnt   <= '0;
            rtype <= '0;
            stat  <= '0;
            cmd   <= '0;
            desc  <= '0;
        end else begin
            if (ev_hit) begin
                case (ev_kind)
                    EV_UNIT: begin
                        cnt <= cnt - 32'd1;
                        if (cmd[CB_SINC]) src <= src + step;
                        if (cmd[CB_DINC]) dst <= dst + step;
                        if (cnt == 32'd1) begin
                            stat[SB_DONE] <= 1'b1;
                            stat[SB_TERM] <= 1'b1;
                        end
                    end
                    EV_ZERO: begin
                        stat[SB_DONE] <= 1'b1;
                        stat[SB_TERM] <= 1'b1;
                    end
                    EV_FAULT: begin
                        stat[SB_AERR] <= 1'b1;
                        stat[SB_HALT] <= 1'b1;
                    end
                    default: ;
                endcase
            end
            // software write takes precedence over an engine update
            if (wr_en) begin
                case (wr_off)
                    3'd0:    src   <= wr_data[AW-1:0];
                    3'd1:    dst   <= wr_data[AW-1:0];
                    3'd2:    cnt   <= wr_data;
                    3'd3:    rtype <= wr_data;
                    3'd4:    stat  <= wr_data & STAT_MASK;
                    3'd5:    cmd   <= wr_data & CMD_MASK;
                    3'd6:    desc  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    assign runnable = stat[SB_EN] & stat[SB_DIRECT] & ~stat[SB_HALT] & ~stat[SB_DONE];

endmodule

// File: rtl/mdma_rr.sv
module mdma_rr #(
    parameter int N   = 6,
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    input  logic           take,
    output logic           any,
    output logic [CHW-1:0] gidx
);

    logic [CHW-1:0] last_q;

    always_comb begin
        int idx;
        any  = 1'b0;
        gidx = '0;
        idx  = 0;
        for (int k = 1; k <= N; k++) begin
            idx = int'(last_q) + k;
            if (idx >= N) idx = idx - N;
            if (!any && req[idx]) begin
                any  = 1'b1;
                gidx = CHW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= CHW'(N - 1);
        else if (take) last_q <= gidx;
    end

endmodule

// File: rtl/mdma_engine.sv
module mdma_engine
    import mdma_pkg::*;
#(
    parameter int CHW = 3,
    parameter int AW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any_req,
    input  logic [CHW-1:0] gidx,
    input  logic [AW-1:0]  sel_src,
    input  logic [AW-1:0]  sel_dst,
    input  logic [31:0]    sel_cnt,
    input  logic [31:0]    sel_cmd,
    output logic           take,
    output ev_kind_e       ev_kind,
    output logic [CHW-1:0] ev_ch,
    output logic           mem_valid,
    output logic           mem_we,
    output logic [1:0]     mem_size,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic           mem_ready,
    input  logic [31:0]    mem_rdata
);

    eng_state_e     state_q, state_d;
    logic [CHW-1:0] cur_ch;
    logic [AW-1:0]  src_q, dst_q;
    logic           sinc_q, dinc_q;
    logic [2:0]     code_q;
    logic [3:0]     beat_q, words_q;
    logic [31:0]    rbuf;
    logic [2:0]     sel_code;
    logic           last_beat;
    logic [AW-1:0]  beat_off;

    assign sel_code  = sel_cmd[10:8];
    assign last_beat = (beat_q == words_q - 4'd1);
    assign beat_off  = AW'({beat_q, 2'b00});

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            sinc_q  <= 1'b0;
            dinc_q  <= 1'b0;
            code_q  <= '0;
            beat_q  <= '0;
            words_q <= 4'd1;
            rbuf    <= '0;
        end else begin
            if (state_q == ST_IDLE && take) begin
                cur_ch  <= gidx;
                src_q   <= sel_src;
                dst_q   <= sel_dst;
                sinc_q  <= sel_cmd[CB_SINC];
                dinc_q  <= sel_cmd[CB_DINC];
                code_q  <= sel_code;
                beat_q  <= '0;
                words_q <= unit_words(sel_code);
            end
            if (state_q == ST_READ && mem_ready)  rbuf   <= mem_rdata;
            if (state_q == ST_WRITE && mem_ready) beat_q <= beat_q + 4'd1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_req && code_ok(sel_code) && sel_cnt != 32'd0) state_d = ST_READ;
            ST_READ:  if (mem_ready) state_d = ST_WRITE;
            ST_WRITE: if (mem_ready) state_d = last_beat ? ST_IDLE : ST_READ;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take      = 1'b0;
        ev_kind   = EV_NONE;
        ev_ch     = cur_ch;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = unit_msize(code_q);
        mem_wdata = rbuf;
        unique case (state_q)
            ST_IDLE: begin
                take  = any_req;
                ev_ch = gidx;
                if (any_req) begin
                    if (!code_ok(sel_code))      ev_kind = EV_FAULT;
                    else if (sel_cnt == 32'd0)   ev_kind = EV_ZERO;
                end
            end
            ST_READ: begin
                mem_valid = 1'b1;
                mem_addr  = sinc_q ? src_q + beat_off : src_q;
            end
            ST_WRITE: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dinc_q ? dst_q + beat_off : dst_q;
                if (mem_ready && last_beat) ev_kind = EV_UNIT;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mdma_ctrl.sv
module mdma_ctrl
    import mdma_pkg::*;
#(
    parameter int N  = 6,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [9:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [1:0]    mem_size,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic [31:0]   mem_rdata,
    output logic          irq
);

    localparam int CHW = (N > 1) ? $clog2(N) : 1;
    localparam logic [9:0] A_GCTL = 10'h300;
    localparam logic [9:0] A_PEND = 10'h304;

    logic [AW-1:0]  src_a [N];
    logic [AW-1:0]  dst_a [N];
    logic [31:0]    cnt_a [N];
    logic [31:0]    rtp_a [N];
    logic [31:0]    stat_a[N];
    logic [31:0]    cmd_a [N];
    logic [31:0]    dsc_a [N];
    logic [N-1:0]   runnable, req, pend;
    logic [31:0]    gctl;
    logic           any_req, take;
    logic [CHW-1:0] gidx, ev_ch, rd_ch;
    ev_kind_e       ev_kind;
    logic           is_ch, run_ok;
    logic [2:0]     off;

    assign is_ch  = (reg_addr[9:5] < 5'(N));
    assign rd_ch  = CHW'(reg_addr[9:5]);
    assign off    = reg_addr[4:2];
    assign run_ok = gctl[GB_EN] & ~gctl[GB_HALT];

    for (genvar i = 0; i < N; i++) begin : g_ch
        mdma_chan #(.AW(AW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr && is_ch && reg_addr[9:5] == 5'(i)),
            .wr_off   (off),
            .wr_data  (reg_wdata),
            .ev_hit   (ev_kind != EV_NONE && ev_ch == CHW'(i)),
            .ev_kind  (ev_kind),
            .src      (src_a[i]),
            .dst      (dst_a[i]),
            .cnt      (cnt_a[i]),
            .rtype    (rtp_a[i]),
            .stat     (stat_a[i]),
            .cmd      (cmd_a[i]),
            .desc     (dsc_a[i]),
            .runnable (runnable[i])
        );
        assign req[i]  = run_ok & runnable[i];
        assign pend[i] = stat_a[i][SB_DONE] & cmd_a[i][CB_IE];
    end

    assign irq = |pend;

    mdma_rr #(.N(N), .CHW(CHW)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .take  (take),
        .any   (any_req),
        .gidx  (gidx)
    );

    mdma_engine #(.CHW(CHW), .AW(AW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req   (any_req),
        .gidx      (gidx),
        .sel_src   (src_a[gidx]),
        .sel_dst   (dst_a[gidx]),
        .sel_cnt   (cnt_a[gidx]),
        .sel_cmd   (cmd_a[gidx]),
        .take      (take),
        .ev_kind   (ev_kind),
        .ev_ch     (ev_ch),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_size  (mem_size),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                          gctl <= '0;
        else if (reg_wr && reg_addr == A_GCTL) gctl <= reg_wdata & GCTL_MASK;
        else if (ev_kind == EV_FAULT)        gctl[GB_AERR] <= 1'b1;
    end

    always_comb begin
        reg_rdata = '0;
        if (is_ch) begin
            case (off)
                3'd0:    reg_rdata = 32'(src_a[rd_ch]);
                3'd1:    reg_rdata = 32'(dst_a[rd_ch]);
                3'd2:    reg_rdata = cnt_a[rd_ch];
                3'd3:    reg_rdata = rtp_a[rd_ch];
                3'd4:    reg_rdata = stat_a[rd_ch];
                3'd5:    reg_rdata = cmd_a[rd_ch];
                3'd6:    reg_rdata = dsc_a[rd_ch];
                default: reg_rdata = '0;
            endcase
        end else if (reg_addr == A_GCTL) begin
            reg_rdata = gctl;
        end else if (reg_addr == A_PEND) begin
            reg_rdata = 32'(pend);
        end
    end

endmodule

// File: rtl/mdma_chk.sv
module mdma_chk
    import mdma_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          mem_valid,
    input logic          mem_we,
    input logic [1:0]    mem_size,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ready,
    input logic          irq,
    input ev_kind_e      ev_kind,
    input logic [31:0]   gctl
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R5

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_we && mem_ready |=> mem_valid && mem_we); // R5

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_size != 2'd3); // R4

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid && (!gctl[GB_EN] || gctl[GB_HALT]) |=> !mem_valid); // R3

    AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev_kind == EV_FAULT && !reg_wr |=> gctl[GB_AERR]); // R10

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev_kind) == EV_UNIT || $past(ev_kind) == EV_ZERO || $past(reg_wr)); // R9

endmodule

bind mdma_ctrl mdma_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_size  (mem_size),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .irq       (irq),
    .ev_kind   (ev_kind),
    .gctl      (gctl)
);

// File: tb/sim_mdma_ctrl.sv
`timescale 1ns/1ps
module sim_mdma_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_valid, mem_we;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [256];
    logic [31:0] wlog_addr [64];
    logic [31:0] wlog_data [64];
    logic [1:0]  wlog_size [64];
    int          wcnt = 0;
    int          acc = 0;
    logic        log_clr = 1'b0;

    always #5 clk = ~clk;

    mdma_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .mem_valid (mem_valid),
        .mem_we (mem_we), .mem_size (mem_size), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_ready (mem_ready), .mem_rdata (mem_rdata),
        .irq (irq)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    // memory model: one wait cycle per access, logs every write
    always @(posedge clk) begin
        if (log_clr) begin
            wcnt <= 0;
            acc  <= 0;
        end else if (mem_valid && mem_ready) begin
            acc <= acc + 1;
            if (mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                if (wcnt < 64) begin
                    wlog_addr[wcnt] <= mem_addr;
                    wlog_data[wcnt] <= mem_wdata;
                    wlog_size[wcnt] <= mem_size;
                end
                wcnt <= wcnt + 1;
            end
        end
        mem_ready <= mem_valid && !mem_ready;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [9:0] ca(input int ch, input int o);
        return 10'(ch * 32 + o);
    endfunction

    task automatic clear_log();
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    task automatic wait_done(input int ch);
        logic [31:0] s;
        for (int t = 0; t < 3000; t++) begin
            rd(ca(ch, 16), s);
            if (s[3]) break;
        end
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] n, input logic [31:0] c);
        wr(ca(ch, 0), s);
        wr(ca(ch, 4), d);
        wr(ca(ch, 8), n);
        wr(ca(ch, 20), c);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(ca(0, 16), v); chk("R1 status", v, 0);
        rd(ca(5, 8), v);  chk("R1 count", v, 0);
        rd(10'h300, v);   chk("R1 control", v, 0);
        rd(10'h304, v);   chk("R1 pending", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 mem_valid", {31'd0, mem_valid}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(ca(3, 0), 32'h1234_5678);   rd(ca(3, 0), v);  chk("R2 source", v, 32'h1234_5678);
        wr(ca(2, 12), 32'h0000_0017);  rd(ca(2, 12), v); chk("R2 request type", v, 32'h17);
        wr(ca(5, 24), 32'hCAFE_0000);  rd(ca(5, 24), v); chk("R2 descriptor", v, 32'hCAFE_0000);
        wr(ca(4, 16), 32'hFFFF_FFFF);  rd(ca(4, 16), v); chk("R2 status mask", v, 32'h8000_005F);
        wr(ca(4, 16), 32'h0);
        wr(ca(4, 20), 32'hFFFF_FFFF);  rd(ca(4, 20), v); chk("R2 command mask", v, 32'h00C0_F783);
        wr(ca(4, 20), 32'h0);
        wr(10'h300, 32'hFFFF_FFFF);    rd(10'h300, v);   chk("R2 control mask", v, 32'h0000_030D);
        wr(10'h300, 32'h0);
        wr(10'h0C0, 32'hFFFF_FFFF);    rd(10'h0C0, v);   chk("R2 unmapped", v, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        clear_log();
        wr(10'h300, 32'h1);
        setup(0, 32'h000, 32'h200, 3, 32'h00C0_0002);
        wr(ca(0, 16), 32'h8000_0001);
        wait_done(0);
        for (int i = 0; i < 3; i++) chk("R5 copied word", mem[128 + i], 32'hA000_0000 + 32'(i));
        rd(ca(0, 8), v);  chk("R7 count at end", v, 0);
        rd(ca(0, 16), v); chk("R8 done and terminated", v, 32'h8000_000B);
        rd(ca(0, 0), v);  chk("R6 source advanced", v, 32'h00C);
        rd(10'h304, v);   chk("R9 pending bit", v, 32'h1);
        chk("R9 irq high", {31'd0, irq}, 1);
        wr(ca(0, 16), 32'h0);
        rd(10'h304, v);   chk("R9 pending cleared", v, 0);
        chk("R9 irq low", {31'd0, irq}, 0);
    endtask

    task automatic t_burst16();
        logic [31:0] v;
        clear_log();
        setup(1, 32'h040, 32'h300, 2, 32'h0040_0300);
        wr(ca(1, 16), 32'h8000_0001);
        wait_done(1);
        chk("R4 sixteen-byte writes", 32'(wcnt), 8);
        for (int i = 0; i < 8; i++) begin
            chk("R6 fixed source, stepping destination", wlog_addr[i], 32'h300 + 32'(4 * i));
            chk("R6 fixed source data", wlog_data[i], 32'hA000_0010);
        end
        rd(10'h304, v); chk("R9 no pending without enable", v, 0);
        wr(ca(1, 16), 32'h0);
    endtask

    task automatic t_narrow();
        logic [31:0] v;
        clear_log();
        setup(2, 32'h010, 32'h100, 3, 32'h00C0_0100);
        wr(ca(2, 16), 32'h8000_0001);
        wait_done(2);
        chk("R4 byte writes", 32'(wcnt), 3);
        for (int i = 0; i < 3; i++) begin
            chk("R6 byte address step", wlog_addr[i], 32'h100 + 32'(i));
            chk("R4 byte size code", {30'd0, wlog_size[i]}, 0);
        end
        rd(ca(2, 0), v); chk("R6 source after bytes", v, 32'h013);
        rd(ca(2, 4), v); chk("R6 destination after bytes", v, 32'h103);
        wr(ca(2, 16), 32'h0);
        clear_log();
        setup(3, 32'h000, 32'h380, 1, 32'h00C0_0400);
        wr(ca(3, 16), 32'h8000_0001);
        wait_done(3);
        chk("R4 thirty-two-byte writes", 32'(wcnt), 8);
        chk("R6 last word address", wlog_addr[7], 32'h39C);
        rd(ca(3, 4), v); chk("R6 destination after 32 bytes", v, 32'h3A0);
        wr(ca(3, 16), 32'h0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        wr(10'h300, 32'h0);
        clear_log();
        setup(0, 32'h000, 32'h200, 2, 32'h00C0_0000);
        wr(ca(0, 16), 32'h8000_0001);
        repeat (40) @(negedge clk);
        chk("R3 global off blocks", 32'(acc), 0);
        wr(10'h300, 32'h9);
        repeat (40) @(negedge clk);
        chk("R3 global halt blocks", 32'(acc), 0);
        wr(ca(0, 16), 32'h0000_0001);
        wr(10'h300, 32'h1);
        repeat (40) @(negedge clk);
        chk("R3 direct-mode bit needed", 32'(acc), 0);
        wr(ca(0, 16), 32'h8000_0005);
        repeat (40) @(negedge clk);
        chk("R3 channel halt blocks", 32'(acc), 0);
        rd(ca(0, 8), v); chk("R7 count untouched while gated", v, 2);
        wr(ca(0, 16), 32'h8000_0001);
        wait_done(0);
        chk("R3 runs once released", 32'(wcnt), 2);
        wr(ca(0, 16), 32'h0);
    endtask

    task automatic t_zero_fault();
        logic [31:0] v;
        clear_log();
        setup(4, 32'h000, 32'h200, 0, 32'h00C0_0000);
        wr(ca(4, 16), 32'h8000_0001);
        repeat (10) @(negedge clk);
        rd(ca(4, 16), v); chk("R8 zero count completes", v, 32'h8000_000B);
        chk("R8 zero count no access", 32'(acc), 0);
        wr(ca(4, 16), 32'h0);
        setup(5, 32'h000, 32'h200, 2, 32'h00C0_0500);
        wr(ca(5, 16), 32'h8000_0001);
        repeat (10) @(negedge clk);
        rd(ca(5, 16), v); chk("R10 channel fault bits", v, 32'h8000_0015);
        rd(10'h300, v);   chk("R10 global error bit", v, 32'h5);
        rd(ca(5, 8), v);  chk("R10 count kept", v, 2);
        chk("R10 no access", 32'(acc), 0);
        wr(ca(5, 16), 32'h0);
        wr(10'h300, 32'h1);
    endtask

    task automatic t_rr();
        wr(10'h300, 32'h0);
        clear_log();
        setup(1, 32'h000, 32'h200, 2, 32'h00C0_0000);
        setup(2, 32'h020, 32'h280, 2, 32'h00C0_0000);
        wr(ca(1, 16), 32'h8000_0001);
        wr(ca(2, 16), 32'h8000_0001);
        wr(10'h300, 32'h1);
        wait_done(1);
        wait_done(2);
        chk("R11 four units", 32'(wcnt), 4);
        chk("R11 first two alternate", {31'd0, wlog_addr[0][7] ^ wlog_addr[1][7]}, 1);
        chk("R11 third follows first", wlog_addr[2], wlog_addr[0] + 32'd4);
        chk("R11 fourth follows second", wlog_addr[3], wlog_addr[1] + 32'd4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_basic();
        t_burst16();
        t_narrow();
        t_gate();
        t_zero_fault();
        t_rr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule